// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block moves transmit frames out of system memory under the control of a ring of 8-byte descriptors. Software builds descriptors in memory, sets the ring base, enables the engine and writes the activate register. The engine then walks the ring from its current position. For each descriptor marked ready it reads the buffer and streams its bytes, in address order, on a byte-wide valid/ready stream. It then hands the descriptor back to software by rewriting its first word with the ready bit cleared. After that it moves either to the next slot or back to the ring base.

A frame may be gathered from several chained buffers. The final buffer of a frame carries a last flag, which marks the stream's final beat and raises a frame event. Every consumed descriptor raises a buffer event. A frame that grows past a fixed byte cap is cut short: the overflowing buffer is truncated and a babble event pulses. Memory is reached through one word-wide port that holds each request until acknowledged.

Top module: `txring_engine`

## Requirements
- R1: Descriptor word 0 holds the flags in bits 31:16 and the byte length in bits 15:0. Word 1, at descriptor address +4, holds the buffer byte address. Buffer bytes leave on `tx_tdata` in ascending address order, and the byte at address a sits in bits [31-8*(a mod 4) -: 8] of its memory word. Data and last are held while valid is high and ready is low.
- R2: The walk ends at the first descriptor whose ready flag (word 0 bit 31) is clear. That descriptor is left untouched, and `busy` falls.
- R3: A consumed descriptor with the last flag (word 0 bit 27) marks its final streamed byte with `tx_tlast` and pulses `ev_tx_frame` once. No other beat carries `tx_tlast`.
- R4: Every consumed descriptor pulses `ev_tx_buf` exactly once.
- R5: After its bytes are sent, a descriptor's word 0 is rewritten with bit 31 cleared and all other bits unchanged. Word 1 is not written.
- R6: The next descriptor is at the ring base when the wrap flag (word 0 bit 29) is set, and at the current address + 8 otherwise. The position is kept between activations.
- R7: A frame holds at most MAX_FRAME bytes (2032). A buffer that would pass the cap is truncated to the bytes that remain, and `ev_babble` pulses. The byte count restarts after each last-flagged descriptor and at each activation.
- R8: One activation consumes at most MAX_DESC descriptors (1024). A following activation resumes at the next one.
- R9: A write to the ring-base register (select 1) clears the low two bits of the value and moves the current position to that base.
- R10: An activate write (select 2) is ignored unless control bit 1 (select 0) is set. No memory access, beat or event follows it.
- R11: `busy` is high from the second cycle after an accepted activate until the walk ends. Activate and ring-base writes made while busy are ignored.
- R12: Memory requests are word aligned and keep their address and direction stable until `mem_ack`.
- R13: A descriptor whose effective length is zero produces no stream beat but is still written back and counted.
- R14: After reset, `busy`, `mem_req` and `tx_tvalid` are low, the engine is disabled and the ring base and position are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 ring base, 2 activate |
| reg_wdata | input | 32 | Register write data |
| busy | output | 1 | Walk in progress |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | One-cycle completion of the pending request |
| tx_tdata | output | 8 | Stream byte |
| tx_tvalid | output | 1 | Stream byte valid |
| tx_tready | input | 1 | Stream sink ready |
| tx_tlast | output | 1 | Final byte of a frame |
| ev_tx_buf | output | 1 | Descriptor consumed pulse |
| ev_tx_frame | output | 1 | Frame completed pulse |
| ev_babble | output | 1 | Frame cap truncation pulse |

## Verification
The properties assume that the memory side pulses `mem_ack` for one cycle only while a request is pending, with `mem_rdata` valid in that cycle. The bench memory model follows this rule. It acknowledges only an outstanding request, after a random stall, and always drops the acknowledge in the next cycle. The stream sink may withhold `tx_tready` in any cycle, and the bench toggles it at random so that held beats are exercised. Descriptor and buffer regions stay apart, so a walk never rewrites the data it is still streaming.

// File: rtl/txr_pkg.sv
package txr_pkg;
  localparam int WORD_W    = 32;
  localparam int LANES     = WORD_W / 8;
  localparam int LANE_BITS = $clog2(LANES);
  localparam int LEN_W     = 16;

  localparam int FLG_READY = 15;
  localparam int FLG_WRAP  = 13;
  localparam int FLG_LAST  = 11;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_RING = 2'd1;
  localparam logic [1:0] SEL_KICK = 2'd2;
  localparam int CTRL_EN_BIT = 1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_ADR,
    ST_BUFRD,
    ST_BEAT,
    ST_WBACK
  } walk_state_t;
endpackage

// File: rtl/txr_regs.sv
module txr_regs
  import txr_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              busy,
  output logic [ADDR_W-1:0] ring_base,
  output logic              base_load,
  output logic              kick
);
  logic enable_q;
  logic unused_bit0;

  assign unused_bit0 = wr_data[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      enable_q  <= 1'b0;
      ring_base <= '0;
      base_load <= 1'b0;
      kick      <= 1'b0;
    end else begin
      base_load <= 1'b0;
      kick      <= 1'b0;
      if (wr_en) begin
        case (wr_sel)
          SEL_CTRL: enable_q <= wr_data[CTRL_EN_BIT];
          SEL_RING: if (!busy) begin
            ring_base <= {wr_data[ADDR_W-1:2], 2'b00};
            base_load <= 1'b1;
          end
          SEL_KICK: if (enable_q && !busy) kick <= 1'b1;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/txr_lane_sel.sv
module txr_lane_sel
  import txr_pkg::*;
(
  input  logic [WORD_W-1:0]    word,
  input  logic [LANE_BITS-1:0] lane,
  output logic [7:0]           byte_o
);
  logic [7:0] lanes [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lanes[g] = word[WORD_W-1-8*g -: 8];
  end

  assign byte_o = lanes[lane];
endmodule

// File: rtl/txr_walker.sv
module txr_walker
  import txr_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int MAX_FRAME = 2032,
  parameter int MAX_DESC  = 1024
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    ring_base,
  input  logic                 base_load,
  input  logic                 kick,
  output logic                 busy,
  output logic                 mem_req,
  output logic                 mem_we,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic [WORD_W-1:0]    mem_wdata,
  input  logic [WORD_W-1:0]    mem_rdata,
  input  logic                 mem_ack,
  output logic [WORD_W-1:0]    word_q,
  output logic [LANE_BITS-1:0] lane,
  output logic                 beat_valid,
  input  logic                 beat_ready,
  output logic                 beat_last,
  output logic                 ev_buf,
  output logic                 ev_frame,
  output logic                 ev_babble
);
  localparam int FRM_W = $clog2(MAX_FRAME + 1);
  localparam int CNT_W = $clog2(MAX_DESC + 1);

  walk_state_t       state;
  logic [ADDR_W-1:0] cur_ptr;
  logic [ADDR_W-1:0] bptr;
  logic [LEN_W-1:0]  flags_q;
  logic [LEN_W-1:0]  len_q;
  logic [LEN_W-1:0]  remain;
  logic [FRM_W-1:0]  frame_cnt;
  logic [CNT_W-1:0]  desc_cnt;
  logic              trunc_q;

  logic [LEN_W-1:0]  room;
  logic              over;
  logic [LEN_W-1:0]  eff_len;

  assign room    = LEN_W'(MAX_FRAME) - LEN_W'(frame_cnt);
  assign over    = len_q > room;
  assign eff_len = over ? room : len_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cur_ptr   <= '0;
      bptr      <= '0;
      flags_q   <= '0;
      len_q     <= '0;
      remain    <= '0;
      frame_cnt <= '0;
      desc_cnt  <= '0;
      trunc_q   <= 1'b0;
      word_q    <= '0;
      ev_buf    <= 1'b0;
      ev_frame  <= 1'b0;
      ev_babble <= 1'b0;
    end else begin
      ev_buf    <= 1'b0;
      ev_frame  <= 1'b0;
      ev_babble <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (base_load) cur_ptr <= ring_base;
          if (kick) begin
            state     <= ST_HDR;
            desc_cnt  <= '0;
            frame_cnt <= '0;
          end
        end
        ST_HDR: if (mem_ack) begin
          flags_q <= mem_rdata[WORD_W-1:LEN_W];
          len_q   <= mem_rdata[LEN_W-1:0];
          state   <= mem_rdata[LEN_W+FLG_READY] ? ST_ADR : ST_IDLE;
        end
        ST_ADR: if (mem_ack) begin
          bptr    <= mem_rdata[ADDR_W-1:0];
          trunc_q <= over;
          remain  <= eff_len;
          state   <= (eff_len == '0) ? ST_WBACK : ST_BUFRD;
        end
        ST_BUFRD: if (mem_ack) begin
          word_q <= mem_rdata;
          state  <= ST_BEAT;
        end
        ST_BEAT: if (beat_ready) begin
          bptr      <= bptr + ADDR_W'(1);
          remain    <= remain - LEN_W'(1);
          frame_cnt <= frame_cnt + FRM_W'(1);
          if (remain == LEN_W'(1))            state <= ST_WBACK;
          else if (&bptr[LANE_BITS-1:0])      state <= ST_BUFRD;
        end
        ST_WBACK: if (mem_ack) begin
          ev_buf    <= 1'b1;
          ev_frame  <= flags_q[FLG_LAST];
          ev_babble <= trunc_q;
          if (flags_q[FLG_LAST]) frame_cnt <= '0;
          cur_ptr  <= flags_q[FLG_WRAP] ? ring_base : cur_ptr + ADDR_W'(8);
          desc_cnt <= desc_cnt + CNT_W'(1);
          state    <= (desc_cnt == CNT_W'(MAX_DESC - 1)) ? ST_IDLE : ST_HDR;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req  = 1'b0;
    mem_we   = 1'b0;
    mem_addr = cur_ptr;
    case (state)
      ST_HDR:   mem_req = 1'b1;
      ST_ADR: begin
        mem_req  = 1'b1;
        mem_addr = cur_ptr + ADDR_W'(4);
      end
      ST_BUFRD: begin
        mem_req  = 1'b1;
        mem_addr = {bptr[ADDR_W-1:LANE_BITS], LANE_BITS'(0)};
      end
      ST_WBACK: begin
        mem_req = 1'b1;
        mem_we  = 1'b1;
      end
      default: ;
    endcase
  end

  assign mem_wdata  = {flags_q & ~(LEN_W'(1) << FLG_READY), len_q};
  assign busy       = (state != ST_IDLE);
  assign beat_valid = (state == ST_BEAT);
  assign beat_last  = flags_q[FLG_LAST] && (remain == LEN_W'(1));
  assign lane       = bptr[LANE_BITS-1:0];
endmodule

// File: rtl/txring_engine.sv
module txring_engine
  import txr_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int MAX_FRAME = 2032,
  parameter int MAX_DESC  = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [31:0]       reg_wdata,
  output logic              busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_ack,
  output logic [7:0]        tx_tdata,
  output logic              tx_tvalid,
  input  logic              tx_tready,
  output logic              tx_tlast,
  output logic              ev_tx_buf,
  output logic              ev_tx_frame,
  output logic              ev_babble
);
  logic [ADDR_W-1:0]    ring_base;
  logic                 base_load;
  logic                 kick;
  logic [WORD_W-1:0]    word_q;
  logic [LANE_BITS-1:0] lane;

  txr_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (reg_wr),
    .wr_sel    (reg_sel),
    .wr_data   (reg_wdata),
    .busy      (busy),
    .ring_base (ring_base),
    .base_load (base_load),
    .kick      (kick)
  );

  txr_walker #(
    .ADDR_W    (ADDR_W),
    .MAX_FRAME (MAX_FRAME),
    .MAX_DESC  (MAX_DESC)
  ) u_walker (
    .clk        (clk),
    .rst        (rst),
    .ring_base  (ring_base),
    .base_load  (base_load),
    .kick       (kick),
    .busy       (busy),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_rdata  (mem_rdata),
    .mem_ack    (mem_ack),
    .word_q     (word_q),
    .lane       (lane),
    .beat_valid (tx_tvalid),
    .beat_ready (tx_tready),
    .beat_last  (tx_tlast),
    .ev_buf     (ev_tx_buf),
    .ev_frame   (ev_tx_frame),
    .ev_babble  (ev_babble)
  );

  txr_lane_sel u_lane (
    .word   (word_q),
    .lane   (lane),
    .byte_o (tx_tdata)
  );
endmodule

// File: rtl/txr_checker.sv
module txr_checker #(
  parameter int ADDR_W    = 32,
  parameter int MAX_FRAME = 2032
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [31:0]       mem_wdata,
  input logic              mem_ack,
  input logic [7:0]        tx_tdata,
  input logic              tx_tvalid,
  input logic              tx_tready,
  input logic              tx_tlast,
  input logic              ev_tx_buf,
  input logic              ev_tx_frame,
  input logic              ev_babble
);
  logic [15:0] beats_in_frame;

  always_ff @(posedge clk) begin
    if (rst || !busy || ev_tx_frame) beats_in_frame <= '0;
    else if (tx_tvalid && tx_tready)  beats_in_frame <= beats_in_frame + 16'd1;
  end

  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R12
  AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr[1:0] == 2'b00)); // R12
  AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (tx_tvalid && !tx_tready) |=> (tx_tvalid && $stable(tx_tdata) && $stable(tx_tlast))); // R1
  AST_WB_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> !mem_wdata[31]); // R5
  AST_FRAME_WITH_BUF: assert property (@(posedge clk) disable iff (rst)
    ev_tx_frame |-> ev_tx_buf); // R3
  AST_BABBLE_WITH_BUF: assert property (@(posedge clk) disable iff (rst)
    ev_babble |-> ev_tx_buf); // R7
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mem_req && !tx_tvalid)); // R2
  AST_FRAME_CAP: assert property (@(posedge clk) disable iff (rst)
    beats_in_frame <= 16'(MAX_FRAME)); // R7
endmodule

bind txring_engine txr_checker #(.ADDR_W(ADDR_W), .MAX_FRAME(MAX_FRAME)) u_txr_checker (
  .clk         (clk),
  .rst         (rst),
  .busy        (busy),
  .mem_req     (mem_req),
  .mem_we      (mem_we),
  .mem_addr    (mem_addr),
  .mem_wdata   (mem_wdata),
  .mem_ack     (mem_ack),
  .tx_tdata    (tx_tdata),
  .tx_tvalid   (tx_tvalid),
  .tx_tready   (tx_tready),
  .tx_tlast    (tx_tlast),
  .ev_tx_buf   (ev_tx_buf),
  .ev_tx_frame (ev_tx_frame),
  .ev_babble   (ev_babble)
);

// File: tb/test_txring_engine.sv
module test_txring_engine;
  localparam int MEMW      = 8192;
  localparam int MAX_FRAME = 2032;
  localparam int MAX_DESC  = 1024;
  localparam int WD_LIMIT  = 190000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic        busy, mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [7:0]  tx_tdata;
  logic        tx_tvalid, tx_tlast, ev_tx_buf, ev_tx_frame, ev_babble;
  logic        tx_tready = 1'b1;

  logic        pk_en = 1'b0;
  logic [31:0] pk_addr = '0, pk_data = '0;

  logic [31:0] mem    [MEMW];
  logic [31:0] expmem [MEMW];
  logic [8:0]  got_q[$];
  logic [8:0]  exp_q[$];
  int n_txb = 0, n_txf = 0, n_bab = 0, hs_bad = 0, cyc = 0;
  int vectors = 0, miscompares = 0;
  int e_txb, e_txf, e_bab, last_beats;
  logic [31:0] exp_ptr = '0, base_m = '0;
  logic        prev_pend = 1'b0;
  logic [31:0] prev_addr = '0;
  bit          finished = 1'b0;

  always #5 clk = ~clk;

  txring_engine i_txring_engine (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .tx_tdata(tx_tdata), .tx_tvalid(tx_tvalid), .tx_tready(tx_tready), .tx_tlast(tx_tlast),
    .ev_tx_buf(ev_tx_buf), .ev_tx_frame(ev_tx_frame), .ev_babble(ev_babble)
  );

  // memory model: acknowledges only a pending request, one-cycle pulse
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
      prev_pend <= 1'b0;
      for (int i = 0; i < MEMW; i++) mem[i] <= '0;
    end else begin
      if ((prev_pend && (!mem_req || mem_addr != prev_addr)) ||
          (mem_req && mem_addr[1:0] != 2'b00)) hs_bad <= hs_bad + 1;
      prev_pend <= mem_req && !mem_ack;
      prev_addr <= mem_addr;
      if (pk_en) mem[pk_addr[14:2]] <= pk_data;
      if (mem_req && !mem_ack && ($urandom % 4 != 0)) begin
        mem_ack   <= 1'b1;
        mem_rdata <= mem[mem_addr[14:2]];
        if (mem_we) mem[mem_addr[14:2]] <= mem_wdata;
      end else begin
        mem_ack <= 1'b0;
      end
      if (tx_tvalid && tx_tready) got_q.push_back({tx_tlast, tx_tdata});
      if (ev_tx_buf)   n_txb <= n_txb + 1;
      if (ev_tx_frame) n_txf <= n_txf + 1;
      if (ev_babble)   n_bab <= n_bab + 1;
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      tx_tready = ($urandom % 4) != 0;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint got, input longint exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    wait (cyc >= WD_LIMIT);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: got %0d cycles expected fewer than %0d", cyc, WD_LIMIT);
      summary();
      $finish;
    end
  end

  task automatic poke(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    pk_en = 1'b1; pk_addr = a; pk_data = d;
    @(negedge clk);
    pk_en = 1'b0;
  endtask

  task automatic put_desc(input logic [31:0] a, input logic [15:0] fl,
                          input logic [15:0] len, input logic [31:0] b);
    poke(a, {fl, len});
    poke(a + 32'd4, b);
  endtask

  task automatic reg_write(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic set_ring(input logic [31:0] v);
    reg_write(2'd1, v);
    base_m  = {v[31:2], 2'b00};
    exp_ptr = base_m;
  endtask

  function automatic logic [7:0] byte_at(input logic [31:0] a);
    logic [31:0] w;
    w = expmem[a[14:2]];
    return w[31 - 8*a[1:0] -: 8];
  endfunction

  // reference walk computed from the requirements on a copy of memory
  task automatic ref_walk();
    logic [31:0] p, w0, b;
    int fc, n, len, room, eff;
    for (int i = 0; i < MEMW; i++) expmem[i] = mem[i];
    exp_q.delete();
    e_txb = 0; e_txf = 0; e_bab = 0;
    p = exp_ptr; fc = 0; n = 0;
    while (n < MAX_DESC) begin
      w0 = expmem[p[14:2]];
      if (!w0[31]) break;
      len  = int'(w0[15:0]);
      b    = expmem[(p + 32'd4) >> 2];
      room = MAX_FRAME - fc;
      if (len > room) begin eff = room; e_bab++; end
      else eff = len;
      for (int k = 0; k < eff; k++)
        exp_q.push_back({(k == eff - 1) && w0[27], byte_at(b + 32'(k))});
      fc += eff;
      if (w0[27]) begin e_txf++; fc = 0; end
      e_txb++;
      expmem[p[14:2]] = w0 & 32'h7FFF_FFFF;
      p = w0[29] ? base_m : p + 32'd8;
      n++;
    end
    exp_ptr = p;
  endtask

  task automatic wait_idle();
    repeat (2) @(negedge clk);
    while (busy && cyc < WD_LIMIT) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic run_walk(input bit extra);
    int gb, tb0, tf0, bb0, nb, bad;
    ref_walk();
    gb = got_q.size(); tb0 = n_txb; tf0 = n_txf; bb0 = n_bab;
    reg_write(2'd2, 32'd0);
    if (extra) begin
      @(negedge clk);
      chk(busy == 1'b1, "R11 busy after activate", busy, 1);
      reg_write(2'd2, 32'd0);
      reg_write(2'd1, 32'h0000_7000);
    end
    wait_idle();
    nb = got_q.size() - gb;
    last_beats = nb;
    chk(nb == exp_q.size(), "R2 beat count", nb, exp_q.size());
    for (int i = 0; i < nb && i < exp_q.size(); i++) begin
      chk(got_q[gb+i][7:0] == exp_q[i][7:0], "R1 byte", got_q[gb+i][7:0], exp_q[i][7:0]);
      chk(got_q[gb+i][8] == exp_q[i][8], "R3 tlast", got_q[gb+i][8], exp_q[i][8]);
    end
    chk(n_txb - tb0 == e_txb, "R4 buffer events", n_txb - tb0, e_txb);
    chk(n_txf - tf0 == e_txf, "R3 frame events", n_txf - tf0, e_txf);
    chk(n_bab - bb0 == e_bab, "R7 babble events", n_bab - bb0, e_bab);
    bad = 0;
    for (int i = 0; i < MEMW; i++) if (mem[i] !== expmem[i]) bad++;
    chk(bad == 0, "R5 descriptor write-back", bad, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0 && mem_req == 1'b0 && tx_tvalid == 1'b0, "R14 reset outputs",
        {busy, mem_req, tx_tvalid}, 0);

    for (int w = 32'h1000; w < 32'h2000; w++) poke(32'(w) << 2, $urandom);

    // R10: activate with engine disabled
    set_ring(32'h100);
    put_desc(32'h100, 16'h8800, 16'd4, 32'h4000);
    put_desc(32'h108, 16'h0000, 16'd0, 32'h0);
    begin
      int gb, tb0;
      gb = got_q.size(); tb0 = n_txb;
      reg_write(2'd2, 32'd0);
      repeat (10) @(negedge clk);
      chk(busy == 1'b0, "R10 disabled stays idle", busy, 0);
      chk(got_q.size() == gb && n_txb == tb0, "R10 no beats or events", got_q.size() - gb, 0);
      chk(mem[32'h100 >> 2][31] == 1'b1, "R10 descriptor untouched", mem[32'h100 >> 2], 32'h8800_0004);
    end

    // R9 R13: unaligned ring base, zero-length last buffer
    reg_write(2'd0, 32'h2);
    set_ring(32'h203);
    put_desc(32'h200, 16'h8000, 16'd5, 32'h4001);
    put_desc(32'h208, 16'h8800, 16'd3, 32'h4102);
    put_desc(32'h210, 16'h8800, 16'd0, 32'h4200);
    put_desc(32'h218, 16'h0000, 16'd0, 32'h0);
    run_walk(1'b0);
    chk(last_beats == 8, "R13 zero-length buffer emits nothing", last_beats, 8);
    chk(got_q[got_q.size()-8][7:0] == byte_at(32'h4001), "R9 walk starts at cleared base",
        got_q[got_q.size()-8][7:0], byte_at(32'h4001));

    // R6: wrap returns to base; position kept
    set_ring(32'h300);
    put_desc(32'h300, 16'h8800, 16'd2, 32'h4300);
    put_desc(32'h308, 16'hA800, 16'd1, 32'h4400);
    put_desc(32'h310, 16'h8800, 16'd6, 32'h4500);
    run_walk(1'b0);
    chk(last_beats == 3, "R6 wrap skips following slot", last_beats, 3);
    put_desc(32'h300, 16'h8800, 16'd7, 32'h4600);
    put_desc(32'h308, 16'h0000, 16'd0, 32'h0);
    run_walk(1'b0);
    chk(last_beats == 7, "R6 resume at ring base", last_beats, 7);

    // R7: frame cap and babble, then count restart
    set_ring(32'h3000);
    put_desc(32'h3000, 16'h8000, 16'd2000, 32'h4000);
    put_desc(32'h3008, 16'h8800, 16'd100, 32'h6000);
    put_desc(32'h3010, 16'h8800, 16'd4, 32'h6100);
    put_desc(32'h3018, 16'h0000, 16'd0, 32'h0);
    run_walk(1'b0);
    chk(last_beats == 2036, "R7 truncated frame length", last_beats, 2036);

    // R8: descriptor limit per activation; R11 extra activate and base write ignored
    set_ring(32'h400);
    for (int i = 0; i < 1100; i++) put_desc(32'h400 + 32'(i) * 8, 16'h8800, 16'd1, 32'h5000);
    put_desc(32'h400 + 32'd1100 * 8, 16'h0000, 16'd0, 32'h0);
    run_walk(1'b1);
    chk(last_beats == MAX_DESC, "R8 limit per activation", last_beats, MAX_DESC);
    run_walk(1'b0);
    chk(last_beats == 1100 - MAX_DESC, "R8 and R11 resume after limit", last_beats, 1100 - MAX_DESC);

    // random rounds
    set_ring(32'h3100);
    for (int r = 0; r < 24; r++) begin
      logic [31:0] p;
      int k;
      bit wrapped;
      if (exp_ptr > 32'h3E00) set_ring(32'h3100);
      p = exp_ptr; k = 1 + int'($urandom % 6); wrapped = 1'b0;
      for (int j = 0; j < k; j++) begin
        logic [15:0] fl;
        fl = 16'h8000;
        if ($urandom % 2 == 0) fl |= 16'h0800;
        if (j == k - 1 && $urandom % 3 == 0) begin fl |= 16'h2000; wrapped = 1'b1; end
        put_desc(p, fl, 16'(1 + $urandom % 40), 32'h4000 + ($urandom % 32'h3F00));
        p += 32'd8;
      end
      if (!wrapped) put_desc(p, 16'h0000, 16'd0, 32'h0);
      run_walk(1'b0);
    end

    chk(hs_bad == 0, "R12 request handshake and alignment", hs_bad, 0);
    finished = 1'b1;
    summary();
    $finish;
  end
endmodule